// File: doc/BRIEF.md
# Host Word-Transfer Handshake and Address Controller

This block sits between a serial-bus remote terminal's protocol engine and a host subsystem. It moves one 16-bit word per transfer over a shared parallel bus. Each transfer uses an active-low request, grant and acknowledge exchange, with a short strobe in the middle of the acknowledge window that the host uses to latch or present data. When the protocol engine accepts a new command it raises `cmd_load`. The block then emits a short new-command pulse and runs a handshake that hands the command word to the host. After that it serves one data-word handshake for each `xfer_start` pulse. The block also sets the bus direction, marks whether the word on the bus is the command or data, and raises a sticky failure flag when the host answers a request too late.

A 5-bit address output tells the host where each word belongs. It shows the latched word-count field of the command while the in-command indication is low, and at all times for mode commands (subaddress all zeros or all ones). In every other case it shows a running word counter. The counter starts at zero for each command and steps after every completed data word. All timing is counted in cycles of the 16 MHz clock. The pulse widths, the transfer length and the grant timeout are parameters.

Top module: `hostxfer_ctrl`

## Requirements
- R1: In reset and after it, `nbg_n`, `req_n`, `ack_n`, `strobe_n` and `hs_fail_n` are 1, while `rw`, `dc`, `in_cmd` and `addr` are 0.
- R2: Sampling `cmd_load` drives `nbg_n` low for exactly NBG_LEN (2) cycles. The cycle after that, `req_n` goes low for the command-word transfer, with `dc` = 0 and `rw` = 0.
- R3: `grant_n` has effect only while `req_n` is low. A grant seen within GRANT_TMO cycles of the request drives `ack_n` low for exactly XFER_CYC (8) cycles. `req_n` stays low for that whole window and returns high together with `ack_n`. The grant may be released once `ack_n` is low.
- R4: `strobe_n` is low for exactly STB_LEN (2) cycles per transfer, on acknowledge cycles 4 and 5 of 8, that is, starting (XFER_CYC-STB_LEN)/2 cycles after `ack_n` falls.
- R5: If no grant is seen during the first GRANT_TMO cycles of a request, `req_n` returns high after exactly GRANT_TMO cycles without any acknowledge, and `hs_fail_n` goes low. `hs_fail_n` stays low through later transfers and returns high in the first cycle of the next `nbg_n` pulse.
- R6: `rw` is 1 only while `req_n` is low during a data-word transfer of a command latched with `cmd_tr` = 1, and is 1 throughout such a transfer. It is 0 during command-word transfers and during receive-direction transfers.
- R7: Completing the command-word transfer sets `in_cmd` = 1 and `dc` = 1. A timed-out command-word transfer leaves `in_cmd` = 0. `xfer_start` is ignored while `in_cmd` = 0. `msg_done` while idle returns `in_cmd` to 0.
- R8: While `in_cmd` = 0, `addr` equals the `cmd_wc` latched by the last `cmd_load`, including at the command-word strobe.
- R9: For a non-mode command with `in_cmd` = 1, `addr` is the word counter. The counter is 0 after each `cmd_load`, adds one after each completed data word (not after a timed-out one), and wraps modulo 32.
- R10: For a mode command (latched `cmd_sa` of 0 or 31), `addr` equals the latched `cmd_wc` whatever the value of `in_cmd` and however many words have completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_load | input | 1 | New command accepted; latches fields and starts the sequence |
| cmd_tr | input | 1 | Command direction: 1 = terminal transmits (data from host) |
| cmd_sa | input | 5 | Subaddress field of the command |
| cmd_wc | input | 5 | Word-count / mode-code field of the command |
| xfer_start | input | 1 | Request one data-word transfer |
| msg_done | input | 1 | Message finished; clears in-command while idle |
| grant_n | input | 1 | Host grant, active low |
| nbg_n | output | 1 | New-command pulse, active low |
| req_n | output | 1 | Transfer request, active low |
| ack_n | output | 1 | Transfer in progress, active low |
| strobe_n | output | 1 | Mid-transfer data strobe, active low |
| rw | output | 1 | 1 while data is needed from the host |
| dc | output | 1 | 0 for the command word, 1 for data words |
| in_cmd | output | 1 | Terminal is servicing a command (data phase) |
| hs_fail_n | output | 1 | Sticky late-grant flag, active low |
| addr | output | 5 | Word count or running word counter |

## Verification
The hardest cases to reach are the edges of the grant window: a grant in the last cycle before the timeout must be accepted, and one cycle later it must lose. The bench therefore shrinks the timeout to a handful of cycles and sweeps the grant delay over every value up to and past it, for both directions. It also lets a command-word transfer time out, which must leave the in-command indication low. A second sweep covers all 32 subaddresses to find both mode encodings. A run of 33 data words drives the counter through its wrap.

// File: rtl/hx_pkg.sv
package hx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NBG  = 2'd1,
    ST_REQ  = 2'd2,
    ST_ACT  = 2'd3
  } hx_state_e;
endpackage

// File: rtl/hx_seq.sv
module hx_seq
  import hx_pkg::*;
#(
  parameter int NBG_LEN   = 2,
  parameter int XFER_CYC  = 8,
  parameter int STB_LEN   = 2,
  parameter int GRANT_TMO = 34
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_load,
  input  logic cmd_tr,
  input  logic xfer_start,
  input  logic msg_done,
  input  logic grant_n,
  output logic nbg_n,
  output logic req_n,
  output logic ack_n,
  output logic strobe_n,
  output logic rw,
  output logic dc,
  output logic in_cmd,
  output logic hs_fail_n,
  output logic word_done
);
  localparam int MAXL     = (XFER_CYC > NBG_LEN) ? XFER_CYC : NBG_LEN;
  localparam int CW       = $clog2(MAXL) + 1;
  localparam int TW       = $clog2(GRANT_TMO) + 1;
  localparam int STB_OFS  = (XFER_CYC - STB_LEN) / 2;
  localparam logic [CW-1:0] NBG_LAST = CW'(NBG_LEN - 1);
  localparam logic [CW-1:0] ACT_LAST = CW'(XFER_CYC - 1);
  localparam logic [CW-1:0] STB_LO   = CW'(STB_OFS);
  localparam logic [CW-1:0] STB_HI   = CW'(STB_OFS + STB_LEN);
  localparam logic [TW-1:0] TMO_LAST = TW'(GRANT_TMO - 1);

  hx_state_e     st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [TW-1:0] tcnt, tcnt_n;
  logic          dat, dat_n, incmd, incmd_n, fail, fail_n, tr, tr_n, done_n;

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    tcnt_n  = tcnt;
    dat_n   = dat;
    incmd_n = incmd;
    fail_n  = fail;
    tr_n    = tr;
    done_n  = 1'b0;
    if (cmd_load) begin
      st_n    = ST_NBG;
      cnt_n   = '0;
      dat_n   = 1'b0;
      incmd_n = 1'b0;
      fail_n  = 1'b0;
      tr_n    = cmd_tr;
    end else begin
      case (st)
        ST_IDLE: begin
          if (msg_done) begin
            incmd_n = 1'b0;
          end else if (xfer_start && incmd) begin
            st_n   = ST_REQ;
            tcnt_n = '0;
          end
        end
        ST_NBG: begin
          if (cnt == NBG_LAST) begin
            st_n   = ST_REQ;
            cnt_n  = '0;
            tcnt_n = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        ST_REQ: begin
          if (!grant_n) begin
            st_n  = ST_ACT;
            cnt_n = '0;
          end else if (tcnt == TMO_LAST) begin
            st_n   = ST_IDLE;
            fail_n = 1'b1;
          end else begin
            tcnt_n = tcnt + 1'b1;
          end
        end
        default: begin
          if (cnt == ACT_LAST) begin
            st_n  = ST_IDLE;
            cnt_n = '0;
            if (dat) begin
              done_n = 1'b1;
            end else begin
              incmd_n = 1'b1;
              dat_n   = 1'b1;
            end
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      tcnt      <= '0;
      dat       <= 1'b0;
      incmd     <= 1'b0;
      fail      <= 1'b0;
      tr        <= 1'b0;
      nbg_n     <= 1'b1;
      req_n     <= 1'b1;
      ack_n     <= 1'b1;
      strobe_n  <= 1'b1;
      rw        <= 1'b0;
      word_done <= 1'b0;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      tcnt      <= tcnt_n;
      dat       <= dat_n;
      incmd     <= incmd_n;
      fail      <= fail_n;
      tr        <= tr_n;
      nbg_n     <= (st_n != ST_NBG);
      req_n     <= !(st_n == ST_REQ || st_n == ST_ACT);
      ack_n     <= (st_n != ST_ACT);
      strobe_n  <= !(st_n == ST_ACT && cnt_n >= STB_LO && cnt_n < STB_HI);
      rw        <= (st_n == ST_REQ || st_n == ST_ACT) && dat_n && tr_n;
      word_done <= done_n;
    end
  end

  assign dc        = dat;
  assign in_cmd    = incmd;
  assign hs_fail_n = !fail;

  a_r3_ack_inside_req: assert property (@(posedge clk) disable iff (rst)
    !ack_n |-> !req_n);
  a_r3_ack_needs_grant: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_n) |-> ($past(!req_n) && $past(!grant_n)));
  a_r4_strobe_inside_ack: assert property (@(posedge clk) disable iff (rst)
    !strobe_n |-> !ack_n);
  a_r5_fail_on_abort: assert property (@(posedge clk) disable iff (rst)
    $fell(hs_fail_n) |-> ($rose(req_n) && ack_n));
  a_r5_nbg_clears_fail: assert property (@(posedge clk) disable iff (rst)
    !nbg_n |-> hs_fail_n);
  a_r6_rw_needs_req: assert property (@(posedge clk) disable iff (rst)
    rw |-> (!req_n && dc));
endmodule

// File: rtl/hx_addr.sv
module hx_addr #(
  parameter int SA_W = 5,
  parameter int WC_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_load,
  input  logic [SA_W-1:0] cmd_sa,
  input  logic [WC_W-1:0] cmd_wc,
  input  logic            word_done,
  input  logic            in_cmd,
  output logic [WC_W-1:0] addr
);
  logic [WC_W-1:0] wc_q, wcnt;
  logic            mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wc_q   <= '0;
      wcnt   <= '0;
      mode_q <= 1'b0;
    end else if (cmd_load) begin
      wc_q   <= cmd_wc;
      wcnt   <= '0;
      mode_q <= (&cmd_sa) || !(|cmd_sa);
    end else if (word_done) begin
      wcnt <= wcnt + 1'b1;
    end
  end

  assign addr = (!in_cmd || mode_q) ? wc_q : wcnt;

  a_r10_mode_addr_steady: assert property (@(posedge clk) disable iff (rst)
    (mode_q && !$past(cmd_load)) |-> $stable(addr));
endmodule

// File: rtl/hostxfer_ctrl.sv
module hostxfer_ctrl #(
  parameter int SA_W      = 5,
  parameter int WC_W      = 5,
  parameter int NBG_LEN   = 2,
  parameter int XFER_CYC  = 8,
  parameter int STB_LEN   = 2,
  parameter int GRANT_TMO = 34
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_load,
  input  logic            cmd_tr,
  input  logic [SA_W-1:0] cmd_sa,
  input  logic [WC_W-1:0] cmd_wc,
  input  logic            xfer_start,
  input  logic            msg_done,
  input  logic            grant_n,
  output logic            nbg_n,
  output logic            req_n,
  output logic            ack_n,
  output logic            strobe_n,
  output logic            rw,
  output logic            dc,
  output logic            in_cmd,
  output logic            hs_fail_n,
  output logic [WC_W-1:0] addr
);
  logic word_done;

  hx_seq #(
    .NBG_LEN  (NBG_LEN),
    .XFER_CYC (XFER_CYC),
    .STB_LEN  (STB_LEN),
    .GRANT_TMO(GRANT_TMO)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_load  (cmd_load),
    .cmd_tr    (cmd_tr),
    .xfer_start(xfer_start),
    .msg_done  (msg_done),
    .grant_n   (grant_n),
    .nbg_n     (nbg_n),
    .req_n     (req_n),
    .ack_n     (ack_n),
    .strobe_n  (strobe_n),
    .rw        (rw),
    .dc        (dc),
    .in_cmd    (in_cmd),
    .hs_fail_n (hs_fail_n),
    .word_done (word_done)
  );

  hx_addr #(
    .SA_W(SA_W),
    .WC_W(WC_W)
  ) u_addr (
    .clk      (clk),
    .rst      (rst),
    .cmd_load (cmd_load),
    .cmd_sa   (cmd_sa),
    .cmd_wc   (cmd_wc),
    .word_done(word_done),
    .in_cmd   (in_cmd),
    .addr     (addr)
  );
endmodule

// File: tb/hostxfer_ctrl_bench.sv
`timescale 1ns/1ps
module hostxfer_ctrl_bench;
  localparam int TMO = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_load = 1'b0, cmd_tr = 1'b0, xfer_start = 1'b0, msg_done = 1'b0;
  logic       grant_n = 1'b1;
  logic [4:0] cmd_sa = '0, cmd_wc = '0;
  logic       nbg_n, req_n, ack_n, strobe_n, rw, dc, in_cmd, hs_fail_n;
  logic [4:0] addr;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  hostxfer_ctrl #(.GRANT_TMO(TMO)) u_hostxfer_ctrl (
    .clk(clk), .rst(rst), .cmd_load(cmd_load), .cmd_tr(cmd_tr),
    .cmd_sa(cmd_sa), .cmd_wc(cmd_wc), .xfer_start(xfer_start),
    .msg_done(msg_done), .grant_n(grant_n), .nbg_n(nbg_n), .req_n(req_n),
    .ack_n(ack_n), .strobe_n(strobe_n), .rw(rw), .dc(dc), .in_cmd(in_cmd),
    .hs_fail_n(hs_fail_n), .addr(addr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Issue a command and check the new-command pulse (R2, R5 clear, R7).
  task automatic issue_cmd(input bit tr, input logic [4:0] sa, input logic [4:0] wc);
    cmd_tr = tr; cmd_sa = sa; cmd_wc = wc; cmd_load = 1'b1;
    @(negedge clk);
    cmd_load = 1'b0;
    chk("R2 nbg first cycle", nbg_n, 0);
    chk("R5 fail cleared at nbg", hs_fail_n, 1);
    chk("R7 in_cmd low at new cmd", in_cmd, 0);
    @(negedge clk);
    chk("R2 nbg second cycle", nbg_n, 0);
    @(negedge clk);
    chk("R2 nbg ended", nbg_n, 1);
    chk("R2 cmd request", req_n, 0);
    chk("R2 dc low for cmd", dc, 0);
  endtask

  // From a negedge with req_n low: grant after dly cycles, observe transfer.
  task automatic run_hs(input int dly, output int acks, output int stbs,
                        output int first, output int saddr, output int sdc,
                        output bit rw_any, output bit rw_all, output int gaps);
    acks = 0; stbs = 0; first = 0; saddr = -1; sdc = -1; gaps = 0;
    rw_any = rw; rw_all = rw;
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      rw_any |= rw; rw_all &= rw;
      if (req_n) gaps++;
    end
    grant_n = 1'b0;
    @(negedge clk);
    grant_n = 1'b1;
    for (int j = 1; j <= 12; j++) begin
      if (!ack_n) begin
        acks++;
        rw_any |= rw; rw_all &= rw;
        if (req_n) gaps++;
      end
      if (!strobe_n) begin
        stbs++;
        if (first == 0) begin first = j; saddr = addr; sdc = dc; end
      end
      if (j < 12) @(negedge clk);
    end
  endtask

  task automatic check_hs(input string tag, input int acks, input int stbs,
                          input int first, input int gaps);
    chk({"R3 ack length ", tag}, acks, 8);
    chk({"R3 req held ", tag}, gaps, 0);
    chk({"R3 req released ", tag}, req_n, 1);
    chk({"R4 strobe width ", tag}, stbs, 2);
    chk({"R4 strobe position ", tag}, first, 4);
  endtask

  task automatic start_data();
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic expect_timeout(input string tag);
    int gaps = 0;
    for (int i = 1; i < TMO; i++) begin
      @(negedge clk);
      if (req_n) gaps++;
    end
    chk({"R5 req held until timeout ", tag}, gaps, 0);
    @(negedge clk);
    chk({"R5 req dropped at timeout ", tag}, req_n, 1);
    chk({"R5 no ack on timeout ", tag}, ack_n, 1);
    chk({"R5 fail flag set ", tag}, hs_fail_n, 0);
  endtask

  initial begin
    int acks, stbs, first, saddr, sdc, gaps;
    bit rw_any, rw_all;
    logic [4:0] wc;
    repeat (3) @(negedge clk);
    chk("R1 nbg reset", nbg_n, 1);
    chk("R1 req reset", req_n, 1);
    chk("R1 ack reset", ack_n, 1);
    chk("R1 strobe reset", strobe_n, 1);
    chk("R1 fail reset", hs_fail_n, 1);
    chk("R1 rw/dc/in_cmd reset", {rw, dc, in_cmd}, 0);
    chk("R1 addr reset", addr, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {nbg_n, req_n, ack_n, strobe_n, hs_fail_n}, 31);

    // R3: grant while not requested has no effect.
    grant_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R3 idle grant ignored ack", ack_n, 1);
      chk("R3 idle grant ignored req", req_n, 1);
    end
    grant_n = 1'b1;

    // R7: data start ignored while in_cmd low.
    start_data();
    @(negedge clk);
    chk("R7 start ignored without cmd", req_n, 1);

    // Sweep grant delays for both directions.
    for (int tr = 0; tr < 2; tr++) begin
      for (int d = 0; d < TMO; d++) begin
        wc = 5'(d + 3 + tr * 8);
        issue_cmd(tr[0], 5'd5, wc);
        run_hs(d, acks, stbs, first, saddr, sdc, rw_any, rw_all, gaps);
        check_hs("cmd", acks, stbs, first, gaps);
        chk("R8 addr at cmd strobe", saddr, int'(wc));
        chk("R2 dc low at cmd strobe", sdc, 0);
        chk("R6 rw low during cmd", rw_any, 0);
        chk("R7 in_cmd after cmd word", in_cmd, 1);
        chk("R7 dc after cmd word", dc, 1);
        chk("R9 counter zero at start", addr, 0);
        for (int k = 0; k < 3; k++) begin
          start_data();
          chk("R3 data request", req_n, 0);
          run_hs((d + k + 1) % TMO, acks, stbs, first, saddr, sdc, rw_any, rw_all, gaps);
          check_hs("data", acks, stbs, first, gaps);
          chk("R9 addr at data strobe", saddr, k);
          chk("R7 dc high at data strobe", sdc, 1);
          if (tr == 1) chk("R6 rw high on transmit", rw_all, 1);
          else         chk("R6 rw low on receive", rw_any, 0);
          chk("R6 rw low after transfer", rw, 0);
        end
        chk("R9 counter after words", addr, 3);
        msg_done = 1'b1;
        @(negedge clk);
        msg_done = 1'b0;
        chk("R7 msg_done clears in_cmd", in_cmd, 0);
        chk("R8 addr shows wc when not in cmd", addr, int'(wc));
      end
    end

    // R10/R9: every subaddress, mode vs non-mode.
    for (int sa = 0; sa < 32; sa++) begin
      bit mode;
      mode = (sa == 0) || (sa == 31);
      wc = 5'(sa) ^ 5'd5;
      issue_cmd(1'b0, 5'(sa), wc);
      run_hs(1, acks, stbs, first, saddr, sdc, rw_any, rw_all, gaps);
      start_data();
      run_hs(0, acks, stbs, first, saddr, sdc, rw_any, rw_all, gaps);
      if (mode) begin
        chk("R10 mode addr at strobe", saddr, int'(wc));
        chk("R10 mode addr after word", addr, int'(wc));
      end else begin
        chk("R9 nonmode addr at strobe", saddr, 0);
        chk("R9 nonmode addr after word", addr, 1);
      end
    end

    // R9: wrap after 33 words.
    issue_cmd(1'b1, 5'd9, 5'd17);
    run_hs(0, acks, stbs, first, saddr, sdc, rw_any, rw_all, gaps);
    for (int k = 0; k < 33; k++) begin
      start_data();
      run_hs(0, acks, stbs, first, saddr, sdc, rw_any, rw_all, gaps);
    end
    chk("R9 counter wraps modulo 32", addr, 1);

    // R5: data timeout, sticky flag, counter not advanced.
    issue_cmd(1'b0, 5'd12, 5'd4);
    run_hs(TMO - 1, acks, stbs, first, saddr, sdc, rw_any, rw_all, gaps);
    check_hs("last-cycle grant", acks, stbs, first, gaps);
    start_data();
    expect_timeout("data");
    chk("R9 timed-out word not counted", addr, 0);
    start_data();
    run_hs(2, acks, stbs, first, saddr, sdc, rw_any, rw_all, gaps);
    check_hs("after fail", acks, stbs, first, gaps);
    chk("R5 fail stays low", hs_fail_n, 0);
    chk("R9 counted after fail", addr, 1);

    // R5/R7: command-word timeout leaves in_cmd low; new command clears flag.
    issue_cmd(1'b0, 5'd3, 5'd6);
    expect_timeout("cmd");
    chk("R7 in_cmd low after cmd timeout", in_cmd, 0);
    start_data();
    @(negedge clk);
    chk("R7 start ignored after cmd timeout", req_n, 1);
    issue_cmd(1'b0, 5'd3, 5'd6);
    run_hs(0, acks, stbs, first, saddr, sdc, rw_any, rw_all, gaps);
    chk("R5 flag high after new cmd", hs_fail_n, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule